// File: doc/BRIEF.md
# Dual-Address DMA Channel

A single DMA channel that copies operands between two locations of a flat address space with little help from the processor. Software loads a source pointer, a destination pointer, a byte count and a control word through a small register port. A software start bit or a peripheral request line then triggers the transfer. Every operand is fetched with a bus read from the source pointer and then stored with a bus write of the same data to the destination pointer, on a simple single-master memory port.

The memory port holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until the memory answers with `mem_ack`. `mem_err` is qualified by `mem_ack`. Operands are 1, 2 or 4 bytes and are carried right-aligned in the 32-bit data lanes. In cycle-steal mode each request moves one operand. In continuous mode one request drains the whole count. The channel ends by setting a done flag, together with a flag that tells whether the source or the destination access failed. An interrupt output follows the done flag when it is enabled.

Register map (`reg_addr`): 0 source pointer, 1 destination pointer, 2 byte count, 3 control, 4 status. Reads are combinational on `reg_rdata`.

Top module: `dma_chan`

## Requirements
- R1: Each operand is a read at the source pointer that completes without error, followed at once by a write of that read data to the destination pointer. A write never starts without that read.
- R2: Writing control with bit 0 (start) set while the channel is idle starts the channel one cycle later, and bit 0 then reads back as 0. With bit 7 (request enable) set, `dreq` high while no access is in progress is also accepted as a request.
- R3: With control bit 1 clear (cycle-steal), each accepted request moves exactly one operand. After it, `mem_req` stays low until the next request, while status busy stays 1.
- R4: With control bit 1 set (continuous), one accepted request moves operands back to back until the count is exhausted.
- R5: Control bits 3:2 select the operand size (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes). After each operand the source pointer advances by the size only when bit 4 is set, and the destination pointer only when bit 5 is set. The count drops by the size and becomes 0 when fewer bytes remain.
- R6: Status bit 0 (done) goes to 1 and bit 1 (busy) goes to 0 when the count reaches zero. A request accepted with a count of zero sets done without any bus access. After reset every register reads 0.
- R7: An error on a read sets status bit 2, and an error on a write sets status bit 3. Either error sets done, clears busy and stops the channel with no further bus access. The failed operand leaves the pointers and the count unchanged.
- R8: Writing status with bit 0 set while idle clears done and both error bits. Accepting a new start also clears them.
- R9: With control bit 8 clear the count is 16 bits wide: bits 23:16 are dropped on write and read back as 0. With bit 8 set all 24 bits are kept.
- R10: Writes to registers 0 to 3 and to status are ignored while busy.
- R11: `irq` is 1 exactly when done is set and control bit 6 (interrupt enable) is 1.
- R12: While `mem_ack` is low, a pending access keeps its address, direction and write data. `mem_size` carries the operand size code. Read data is masked to the operand width before it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| dreq | input | 1 | Peripheral transfer request |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Access address |
| mem_wdata | output | 32 | Write data, right-aligned |
| mem_size | output | 2 | Operand size code |
| mem_rdata | input | 32 | Read data |
| mem_ack | input | 1 | Access completes this cycle |
| mem_err | input | 1 | Completing access failed |
| irq | output | 1 | Completion interrupt |

## Verification
A wrong phase in the sequencer shows on the memory port in the very next cycle: a request that appears or disappears, a wrong direction, or an address that points at the wrong pointer. The bench model compares these on every clock. A wrong pointer or count step first shows as a wrong address on the next operand, one or two cycles later, and at the end as wrong readback values and wrong destination bytes. A wrong status or mask shows only at readback and on `irq`, so these are read back after every scenario.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2
    } phase_t;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } opsize_t;

    // control word, bit 0 is the start bit
    typedef struct packed {
        logic    cnt_wide;   // 8
        logic    req_en;     // 7
        logic    irq_en;     // 6
        logic    dst_inc;    // 5
        logic    src_inc;    // 4
        opsize_t size;       // 3:2
        logic    burst;      // 1
        logic    go;         // 0
    } ctrl_t;

    localparam logic [2:0] RA_SRC  = 3'd0;
    localparam logic [2:0] RA_DST  = 3'd1;
    localparam logic [2:0] RA_CNT  = 3'd2;
    localparam logic [2:0] RA_CTL  = 3'd3;
    localparam logic [2:0] RA_STAT = 3'd4;

    function automatic logic [2:0] size_bytes(input opsize_t s);
        case (s)
            SZ_BYTE: size_bytes = 3'd1;
            SZ_HALF: size_bytes = 3'd2;
            default: size_bytes = 3'd4;
        endcase
    endfunction

    function automatic logic [31:0] lane_mask(input opsize_t s);
        case (s)
            SZ_BYTE: lane_mask = 32'h0000_00FF;
            SZ_HALF: lane_mask = 32'h0000_FFFF;
            default: lane_mask = 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/dma_regfile.sv
module dma_regfile
    import dma_pkg::*;
#(
    parameter int AW         = 32,
    parameter int CNT_W      = 24,
    parameter int CNT_NARROW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    input  logic             take,
    input  logic             step,
    input  logic             fin,
    input  logic             err_src,
    input  logic             err_dst,
    output logic [AW-1:0]    src_ptr,
    output logic [AW-1:0]    dst_ptr,
    output logic [CNT_W-1:0] cnt_eff,
    output ctrl_t            ctrl,
    output logic             busy,
    output logic             done,
    output logic             es_flag,
    output logic             ed_flag,
    output logic             last_op,
    output logic             cnt_zero
);
    localparam logic [CNT_W-1:0] NARROW_MASK = CNT_W'((64'd1 << CNT_NARROW) - 64'd1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_mask;
    logic [CNT_W-1:0] step_bytes;
    logic             wr_ok;

    assign cnt_mask   = ctrl.cnt_wide ? '1 : NARROW_MASK;
    assign cnt_eff    = cnt_q & cnt_mask;
    assign step_bytes = CNT_W'(size_bytes(ctrl.size));
    assign last_op    = (cnt_eff <= step_bytes);
    assign cnt_zero   = (cnt_eff == '0);
    assign wr_ok      = !busy && !take;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_ptr <= '0;
            dst_ptr <= '0;
            cnt_q   <= '0;
            ctrl    <= '0;
            busy    <= 1'b0;
            done    <= 1'b0;
            es_flag <= 1'b0;
            ed_flag <= 1'b0;
        end else begin
            if (reg_we && wr_ok) begin
                case (reg_addr)
                    RA_SRC:  src_ptr <= reg_wdata[AW-1:0];
                    RA_DST:  dst_ptr <= reg_wdata[AW-1:0];
                    RA_CNT:  cnt_q   <= reg_wdata[CNT_W-1:0] & cnt_mask;
                    RA_CTL:  ctrl    <= ctrl_t'(reg_wdata[8:0]);
                    RA_STAT: if (reg_wdata[0]) begin
                        done    <= 1'b0;
                        es_flag <= 1'b0;
                        ed_flag <= 1'b0;
                    end
                    default: ;
                endcase
            end
            if (step) begin
                if (ctrl.src_inc) src_ptr <= src_ptr + AW'(step_bytes);
                if (ctrl.dst_inc) dst_ptr <= dst_ptr + AW'(step_bytes);
                cnt_q <= last_op ? '0 : (cnt_eff - step_bytes);
            end
            if (take) begin
                ctrl.go <= 1'b0;
                busy    <= 1'b1;
                done    <= 1'b0;
                es_flag <= 1'b0;
                ed_flag <= 1'b0;
            end
            if (fin) begin
                busy <= 1'b0;
                done <= 1'b1;
                if (err_src) es_flag <= 1'b1;
                if (err_dst) ed_flag <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic          req_en,
    input  logic          dreq,
    input  logic          burst,
    input  logic          cnt_zero,
    input  logic          last_op,
    input  opsize_t       size,
    input  logic [AW-1:0] src_ptr,
    input  logic [AW-1:0] dst_ptr,
    input  logic          mem_ack,
    input  logic          mem_err,
    input  logic [31:0]   mem_rdata,
    output logic          take,
    output logic          step,
    output logic          fin,
    output logic          err_src,
    output logic          err_dst,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata
);
    phase_t      ph, ph_nx;
    logic [31:0] hold;

    always_comb begin
        ph_nx   = ph;
        take    = 1'b0;
        step    = 1'b0;
        fin     = 1'b0;
        err_src = 1'b0;
        err_dst = 1'b0;
        case (ph)
            PH_IDLE: begin
                if (go || (req_en && dreq)) begin
                    take = 1'b1;
                    if (cnt_zero) fin = 1'b1;
                    else          ph_nx = PH_READ;
                end
            end
            PH_READ: begin
                if (mem_ack) begin
                    if (mem_err) begin
                        fin     = 1'b1;
                        err_src = 1'b1;
                        ph_nx   = PH_IDLE;
                    end else begin
                        ph_nx = PH_WRITE;
                    end
                end
            end
            PH_WRITE: begin
                if (mem_ack) begin
                    if (mem_err) begin
                        fin     = 1'b1;
                        err_dst = 1'b1;
                        ph_nx   = PH_IDLE;
                    end else begin
                        step = 1'b1;
                        if (last_op) begin
                            fin   = 1'b1;
                            ph_nx = PH_IDLE;
                        end else begin
                            ph_nx = burst ? PH_READ : PH_IDLE;
                        end
                    end
                end
            end
            default: ph_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph   <= PH_IDLE;
            hold <= '0;
        end else begin
            ph <= ph_nx;
            if (ph == PH_READ && mem_ack && !mem_err)
                hold <= mem_rdata & lane_mask(size);
        end
    end

    assign mem_req   = (ph != PH_IDLE);
    assign mem_we    = (ph == PH_WRITE);
    assign mem_addr  = mem_we ? dst_ptr : src_ptr;
    assign mem_wdata = hold;

endmodule

// File: rtl/dma_chan.sv
module dma_chan
    import dma_pkg::*;
#(
    parameter int AW         = 32,
    parameter int CNT_W      = 24,
    parameter int CNT_NARROW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          dreq,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    output logic [1:0]    mem_size,
    input  logic [31:0]   mem_rdata,
    input  logic          mem_ack,
    input  logic          mem_err,
    output logic          irq
);
    logic [AW-1:0]    src_ptr, dst_ptr;
    logic [CNT_W-1:0] cnt_eff;
    ctrl_t            ctrl;
    logic             busy, done, es_flag, ed_flag;
    logic             last_op, cnt_zero;
    logic             take, step, fin, err_src, err_dst;
    logic             burst;

    assign burst = ctrl.burst;

    dma_regfile #(.AW(AW), .CNT_W(CNT_W), .CNT_NARROW(CNT_NARROW)) u_regs (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .take(take), .step(step), .fin(fin),
        .err_src(err_src), .err_dst(err_dst),
        .src_ptr(src_ptr), .dst_ptr(dst_ptr), .cnt_eff(cnt_eff), .ctrl(ctrl),
        .busy(busy), .done(done), .es_flag(es_flag), .ed_flag(ed_flag),
        .last_op(last_op), .cnt_zero(cnt_zero)
    );

    dma_engine #(.AW(AW)) u_eng (
        .clk(clk), .rst(rst),
        .go(ctrl.go), .req_en(ctrl.req_en), .dreq(dreq), .burst(burst),
        .cnt_zero(cnt_zero), .last_op(last_op), .size(ctrl.size),
        .src_ptr(src_ptr), .dst_ptr(dst_ptr),
        .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
        .take(take), .step(step), .fin(fin),
        .err_src(err_src), .err_dst(err_dst),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata)
    );

    assign mem_size = ctrl.size;
    assign irq      = done && ctrl.irq_en;

    always_comb begin
        case (reg_addr)
            RA_SRC:  reg_rdata = 32'(src_ptr);
            RA_DST:  reg_rdata = 32'(dst_ptr);
            RA_CNT:  reg_rdata = 32'(cnt_eff);
            RA_CTL:  reg_rdata = 32'(ctrl);
            RA_STAT: reg_rdata = {28'd0, ed_flag, es_flag, busy, done};
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
    parameter int AW    = 32,
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             mem_req,
    input logic             mem_we,
    input logic             mem_ack,
    input logic             mem_err,
    input logic [AW-1:0]    mem_addr,
    input logic             burst,
    input logic             busy,
    input logic             done,
    input logic             irq,
    input logic             step,
    input logic [CNT_W-1:0] cnt_eff
);
    // R1: a write phase opens only right after an error-free read completion
    p_write_after_read_r1: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && !$past(mem_req && mem_we))
            |-> $past(mem_req && !mem_we && mem_ack && !mem_err));

    // R12: unanswered access keeps address and direction
    p_hold_access_r12: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R3: cycle-steal leaves the port idle after each operand
    p_steal_gap_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_ack && !burst) |=> !mem_req);

    // R5: every completed operand lowers the count
    p_count_drops_r5: assert property (@(posedge clk) disable iff (rst)
        step |=> (cnt_eff < $past(cnt_eff)));

    // R6: done and busy are never set together
    p_done_busy_r6: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done);

    // R7: an error ends bus activity
    p_err_stops_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && mem_err) |=> !mem_req);

    // R11: no interrupt while the channel is busy
    p_busy_no_irq_r11: assert property (@(posedge clk) disable iff (rst)
        busy |-> !irq);

endmodule

bind dma_chan dma_chan_chk #(.AW(AW), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst),
    .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_err(mem_err),
    .mem_addr(mem_addr), .burst(burst), .busy(busy), .done(done), .irq(irq),
    .step(step), .cnt_eff(cnt_eff)
);

// File: tb/dma_chan_tb.sv
module dma_chan_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dreq = 1'b0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [1:0]  mem_size;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        mem_err = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit reported = 0;

    always #10 clk = ~clk;   // 50 MHz

    dma_chan u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_size(mem_size), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .mem_err(mem_err), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
        end
    endtask

    // ---------------- memory responder ----------------
    logic [7:0] mem [256];
    int lat    = 0;
    int wcnt   = 0;
    int err_rd = -1;
    int err_wr = -1;

    function automatic logic [7:0] pat(input int i);
        return 8'(i * 7 + 3);
    endfunction

    function automatic int nbytes(input logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    endfunction

    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
            mem_err = 1'b0;
            wcnt    = 0;
        end
        if (!rst && mem_req) begin
            if (wcnt >= lat) begin
                mem_ack = 1'b1;
                if (!mem_we) begin
                    mem_err = (int'(mem_addr) == err_rd);
                    mem_rdata = {mem[8'(mem_addr + 3)], mem[8'(mem_addr + 2)],
                                 mem[8'(mem_addr + 1)], mem[8'(mem_addr)]};
                end else begin
                    mem_err = (int'(mem_addr) == err_wr);
                    if (!mem_err)
                        for (int k = 0; k < nbytes(mem_size); k++)
                            mem[8'(mem_addr + 32'(k))] = mem_wdata[8*k +: 8];
                end
            end else begin
                wcnt++;
            end
        end
    end

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_src, m_dst, m_hold;
    logic [23:0] m_cnt;
    logic [8:0]  m_ctl;
    bit          m_done, m_busy, m_es, m_ed;
    int          m_ph;   // 0 idle, 1 read, 2 write

    always @(posedge clk) begin
        if (rst) begin
            m_src = 0; m_dst = 0; m_hold = 0; m_cnt = 0; m_ctl = 0;
            m_done = 0; m_busy = 0; m_es = 0; m_ed = 0; m_ph = 0;
        end else begin
            logic [23:0] mask, eff;
            int nb, nph;
            bit take, fin, es, ed, stp;
            mask = m_ctl[8] ? 24'hFF_FFFF : 24'h00_FFFF;
            eff  = m_cnt & mask;
            nb   = nbytes(m_ctl[3:2]);
            take = 0; fin = 0; es = 0; ed = 0; stp = 0; nph = m_ph;
            if (m_ph == 0) begin
                if (m_ctl[0] || (m_ctl[7] && dreq)) begin
                    take = 1;
                    if (eff == 0) fin = 1; else nph = 1;
                end
            end else if (m_ph == 1) begin
                if (mem_ack) begin
                    if (mem_err) begin fin = 1; es = 1; nph = 0; end
                    else begin
                        m_hold = mem_rdata & ((nb == 1) ? 32'hFF : (nb == 2) ? 32'hFFFF : 32'hFFFF_FFFF);
                        nph = 2;
                    end
                end
            end else begin
                if (mem_ack) begin
                    if (mem_err) begin fin = 1; ed = 1; nph = 0; end
                    else begin
                        stp = 1;
                        if (int'(eff) <= nb) begin fin = 1; nph = 0; end
                        else nph = m_ctl[1] ? 1 : 0;
                    end
                end
            end
            if (reg_we && !m_busy && !take) begin
                case (reg_addr)
                    3'd0: m_src = reg_wdata;
                    3'd1: m_dst = reg_wdata;
                    3'd2: m_cnt = reg_wdata[23:0] & mask;
                    3'd3: m_ctl = reg_wdata[8:0];
                    3'd4: if (reg_wdata[0]) begin m_done = 0; m_es = 0; m_ed = 0; end
                    default: ;
                endcase
            end
            if (stp) begin
                if (m_ctl[4]) m_src = m_src + nb;
                if (m_ctl[5]) m_dst = m_dst + nb;
                m_cnt = (int'(eff) <= nb) ? 24'd0 : eff - 24'(nb);
            end
            if (take) begin m_ctl[0] = 0; m_busy = 1; m_done = 0; m_es = 0; m_ed = 0; end
            if (fin) begin m_busy = 0; m_done = 1; if (es) m_es = 1; if (ed) m_ed = 1; end
            m_ph = nph;
        end
    end

    // per-cycle comparison of the memory port and interrupt
    always @(negedge clk) begin
        if (!rst) begin
            chk(mem_req == (m_ph != 0), "R3 mem_req", 32'(mem_req), 32'(m_ph != 0));
            if (m_ph != 0) begin
                chk(mem_we == (m_ph == 2), "R1 mem_we", 32'(mem_we), 32'(m_ph == 2));
                chk(mem_addr == ((m_ph == 2) ? m_dst : m_src), "R1 mem_addr",
                    mem_addr, (m_ph == 2) ? m_dst : m_src);
                chk(mem_size == m_ctl[3:2], "R12 mem_size", 32'(mem_size), 32'(m_ctl[3:2]));
                if (m_ph == 2)
                    chk(mem_wdata == m_hold, "R12 mem_wdata", mem_wdata, m_hold);
            end
            chk(irq == (m_done && m_ctl[6]), "R11 irq", 32'(irq), 32'(m_done && m_ctl[6]));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(reg_rdata == exp, tag, reg_rdata, exp);
    endtask

    task automatic wait_end();
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (!m_busy && m_ph == 0) break;
        end
    endtask

    task automatic wait_gap();
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (m_ph == 0) break;
        end
    endtask

    task automatic pulse_req();
        @(negedge clk); dreq = 1'b1;
        @(negedge clk); dreq = 1'b0;
    endtask

    task automatic chk_mem(input int a, input logic [7:0] exp, input string tag);
        chk(mem[a] == exp, tag, 32'(mem[a]), 32'(exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        report();
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = pat(i);
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state (R6)
        rd(3'd4, 32'h0, "R6 reset status");
        rd(3'd0, 32'h0, "R6 reset src");
        rd(3'd3, 32'h0, "R6 reset ctrl");
        chk(irq == 1'b0, "R11 reset irq", 32'(irq), 32'h0);

        // continuous word copy, both pointers incrementing (R1 R2 R4 R5 R6)
        lat = 0;
        wr(3'd3, 32'h13A);
        wr(3'd0, 32'h00); wr(3'd1, 32'h40); wr(3'd2, 32'd16);
        wr(3'd3, 32'h13B);
        rd(3'd3, 32'h13A, "R2 start bit self clears");
        wait_end();
        for (int i = 0; i < 16; i++) chk_mem(32'h40 + i, pat(i), "R1 R4 copied byte");
        rd(3'd0, 32'h10, "R5 src advanced");
        rd(3'd1, 32'h50, "R5 dst advanced");
        rd(3'd2, 32'h0,  "R5 count exhausted");
        rd(3'd4, 32'h1,  "R6 done set busy clear");
        wr(3'd4, 32'h1);
        rd(3'd4, 32'h0,  "R8 done cleared by write");

        // interrupt follows done when enabled (R11)
        lat = 1;
        wr(3'd3, 32'h17A);
        wr(3'd0, 32'h08); wr(3'd1, 32'h70); wr(3'd2, 32'd8);
        wr(3'd3, 32'h17B);
        wait_end();
        chk(irq == 1'b1, "R11 irq with done", 32'(irq), 32'h1);
        wr(3'd4, 32'h1);
        @(negedge clk);
        chk(irq == 1'b0, "R11 irq after clear", 32'(irq), 32'h0);

        // cycle-steal bytes, destination fixed, request line (R3 R5 R10)
        lat = 1;
        wr(3'd3, 32'h190);
        wr(3'd0, 32'h80); wr(3'd1, 32'hC0); wr(3'd2, 32'd3);
        pulse_req();
        wait_gap();
        rd(3'd4, 32'h2, "R3 busy between operands");
        wr(3'd1, 32'hFF);
        wr(3'd3, 32'h000);
        wr(3'd2, 32'd50);
        rd(3'd1, 32'hC0, "R10 dst write ignored while busy");
        rd(3'd3, 32'h190, "R10 ctrl write ignored while busy");
        rd(3'd2, 32'd2, "R10 count write ignored while busy");
        pulse_req(); wait_gap();
        pulse_req(); wait_end();
        chk_mem(32'hC0, pat(32'h82), "R5 fixed dst holds last byte");
        chk_mem(32'hC1, pat(32'hC1), "R5 fixed dst neighbour untouched");
        rd(3'd0, 32'h83, "R5 src advanced by bytes");
        rd(3'd4, 32'h1, "R3 done after last request");
        wr(3'd4, 32'h1);

        // count width selection (R9)
        wr(3'd3, 32'h000);
        wr(3'd2, 32'h12_0004);
        rd(3'd2, 32'h0004, "R9 narrow count drops upper bits");
        wr(3'd3, 32'h100);
        wr(3'd2, 32'h12_0004);
        rd(3'd2, 32'h12_0004, "R9 wide count keeps 24 bits");
        wr(3'd3, 32'h000);
        rd(3'd2, 32'h0004, "R9 narrow readback masks");

        // halfword, odd count saturates (R5 R12)
        lat = 2;
        wr(3'd3, 32'h036);
        wr(3'd0, 32'h20); wr(3'd1, 32'h60); wr(3'd2, 32'd5);
        wr(3'd3, 32'h037);
        wait_end();
        for (int i = 0; i < 6; i++) chk_mem(32'h60 + i, pat(32'h20 + i), "R12 halfword bytes");
        chk_mem(32'h66, pat(32'h66), "R12 no write beyond operand");
        rd(3'd2, 32'h0, "R5 odd count saturates to zero");
        rd(3'd0, 32'h26, "R5 src after three halfwords");
        wr(3'd4, 32'h1);

        // zero count start (R6)
        wr(3'd2, 32'h0);
        wr(3'd3, 32'h001);
        @(negedge clk);
        rd(3'd4, 32'h1, "R6 zero count done without access");
        wr(3'd4, 32'h1);

        // read error on second operand (R7)
        lat = 0; err_rd = 32'h04;
        wr(3'd3, 32'h13A);
        wr(3'd0, 32'h00); wr(3'd1, 32'hA0); wr(3'd2, 32'd8);
        wr(3'd3, 32'h13B);
        wait_end();
        rd(3'd4, 32'h5, "R7 source error status");
        rd(3'd2, 32'd4, "R7 count kept at failed operand");
        rd(3'd0, 32'h04, "R7 src kept at failed operand");
        rd(3'd1, 32'hA4, "R7 dst kept at failed operand");
        err_rd = -1;

        // write error, restart clears old flags (R7 R8)
        err_wr = 32'hE0;
        wr(3'd0, 32'h10); wr(3'd1, 32'hE0); wr(3'd2, 32'd4);
        wr(3'd3, 32'h13B);
        rd(3'd4, 32'h2, "R8 restart clears done and error");
        wait_end();
        rd(3'd4, 32'h9, "R7 destination error status");
        rd(3'd1, 32'hE0, "R7 dst unchanged on write error");
        err_wr = -1;
        wr(3'd4, 32'h1);
        rd(3'd4, 32'h0, "R8 clear removes error bits");

        // request line ignored without request enable (R2)
        wr(3'd3, 32'h110);
        wr(3'd2, 32'd4);
        pulse_req();
        repeat (3) @(negedge clk);
        rd(3'd4, 32'h0, "R2 dreq ignored when disabled");

        report();
        $finish;
    end

endmodule